// File: doc/BRIEF.md
# Per-Line Coherence Controller with Page-Selectable Write Policy

This block keeps the coherence state of every line of one private cache that sits on a shared snooping bus. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The block serves two sources of work. The first is one local read, write or evict request at a time. The second is the stream of transactions that other caches place on the bus, which it snoops. It answers each snooped transaction with a shared-line indication, a data-supply indication and an update-take indication. The data array, the replacement choice and the memory controller sit outside the block.

When the local side writes a line that other caches may hold, the page the line belongs to selects the behaviour through a mode bit supplied with the request. In invalidate mode, the peers' copies are removed before the write completes. In update mode, the written value is broadcast to the peers and they keep their copies. The writer then stays Shared if any peer answered, and becomes Modified otherwise.

A local request runs through a three-state sequencer. FS_IDLE accepts the request. FS_REQ takes the transition FS_REQ to FS_DONE when no bus work is needed or when the bus is granted, and otherwise stays in FS_REQ and holds the bus request. FS_DONE pulses completion for one cycle and returns to FS_IDLE. While FS_REQ waits, the sequencer recomputes the bus command every cycle from the line's current state, so a snoop that changes the line during the wait changes the command that is issued.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0; codes are I=0, S=1, E=2, M=3), loc_ready is 1, and bus_req and loc_done are 0.
- R2: A local read (op code 0) of a line in S, E or M completes without a bus request, reports loc_hit=1, and leaves the state unchanged.
- R3: A local read of an Invalid line issues bus command RD (code 1). The line fills as E when bus_shared_in is 0 in the grant cycle, and as S when it is 1.
- R4: A local write (op code 1) to a line in E or M completes without a bus request, and the line becomes M.
- R5: With loc_upd_mode=0, a local write to an S line issues UPGR (code 3) and a write to an I line issues RDX (code 2). Both end in M.
- R6: With loc_upd_mode=1, a local write to an S or I line issues UPD (code 4). The line ends S if bus_shared_in is 1 in the grant cycle, and M otherwise.
- R7: A snooped RD (code 1) asserts snp_shared when the line is valid and asserts snp_supply when the line is M. An M or E line drops to S.
- R8: A snooped RDX or UPGR sends the line to I, and an M line asserts snp_supply on RDX. A snooped WB (code 5) changes nothing and asserts no response.
- R9: A snooped UPD on a valid line asserts snp_shared and snp_take_upd and keeps a valid copy. An M line supplies the data, and M or E drops to S.
- R10: A local evict (op code 2) of an M line issues WB (code 5) and ends in I. An evict of a clean line ends in I with no bus request.
- R11: While a request waits for grant, a snoop that changes its line makes the next cycle's bus command follow the new state. An evict whose line has become clean completes with no bus transaction.
- R12: loc_done is a one-cycle pulse, loc_ready is 1 only when no request is in flight, and bus_idx stays constant while bus_req waits without grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local request, taken when loc_ready is 1 |
| loc_op | input | 2 | 0 read, 1 write, 2 evict |
| loc_idx | input | IDX_W | Line index of the local request |
| loc_upd_mode | input | 1 | Page write policy: 1 update, 0 invalidate |
| loc_ready | output | 1 | Sequencer idle |
| loc_done | output | 1 | One-cycle completion pulse |
| loc_hit | output | 1 | Request completed with no bus transaction |
| loc_state | output | 2 | Line state after the completed request |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 3 | Command of the requested transaction |
| bus_idx | output | IDX_W | Line index of the requested transaction |
| bus_gnt | input | 1 | Bus grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Some peer holds the line (valid in the grant cycle) |
| snp_valid | input | 1 | Snooped peer transaction present |
| snp_cmd | input | 3 | Snooped command code |
| snp_idx | input | IDX_W | Snooped line index |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the line data |
| snp_take_upd | output | 1 | This cache must write the broadcast value into its copy |

## Verification
The hardest situation to reach is a snoop that lands on the very line a local request is waiting on, in the cycles between raising bus_req and receiving the grant. Random traffic almost never produces it, because a peer transaction would have to arrive at exactly that moment. Directed sequences therefore stage it explicitly. In one, the bench holds back the grant on a write to a Shared line and snoops an RDX on that line, then expects the command to change from UPGR to RDX. In another, it snoops a read on a Modified line that is waiting to evict, then expects the write-back to disappear and the evict to complete as a hit. Random local and snooped traffic with random grant delay and random shared answers covers the rest of the state table.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_NOP = 2'd3
    } lop_t;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPGR = 3'd3,
        BC_UPD  = 3'd4,
        BC_WB   = 3'd5
    } bcmd_t;

    // Bus work needed by a local operation on a line in state st.
    function automatic bcmd_t local_cmd(lop_t op, mesi_t st, logic upd);
        bcmd_t c;
        c = BC_NONE;
        unique case (op)
            OP_RD: if (st == ST_I) c = BC_RD;
            OP_WR: begin
                if (st == ST_S || st == ST_I) begin
                    if (upd)              c = BC_UPD;
                    else if (st == ST_S)  c = BC_UPGR;
                    else                  c = BC_RDX;
                end
            end
            OP_EV: if (st == ST_M) c = BC_WB;
            default: c = BC_NONE;
        endcase
        return c;
    endfunction

    // Line state once the local operation completes.
    function automatic mesi_t local_next(lop_t op, mesi_t st, logic upd, logic shr);
        mesi_t n;
        n = st;
        unique case (op)
            OP_RD: if (st == ST_I) n = shr ? ST_S : ST_E;
            OP_WR: begin
                if (st == ST_E || st == ST_M) n = ST_M;
                else if (upd)                 n = shr ? ST_S : ST_M;
                else                          n = ST_M;
            end
            OP_EV: n = ST_I;
            default: n = st;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/coh_state_table.sv
module coh_state_table
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lwe,
    input  logic [IDX_W-1:0] lidx,
    input  mesi_t            lst,
    input  logic             swe,
    input  logic [IDX_W-1:0] sidx,
    input  mesi_t            sst,
    input  logic [IDX_W-1:0] ridx_a,
    output mesi_t            rd_a,
    input  logic [IDX_W-1:0] ridx_b,
    output mesi_t            rd_b,
    output mesi_t            states [NUM_LINES]
);

    mesi_t line_q [NUM_LINES];

    // Local completion wins over a snoop to the same line in one cycle.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                line_q[g] <= ST_I;
            else if (lwe && lidx == IDX_W'(g))
                line_q[g] <= lst;
            else if (swe && sidx == IDX_W'(g))
                line_q[g] <= sst;
        end
    end

    assign rd_a   = line_q[ridx_a];
    assign rd_b   = line_q[ridx_b];
    assign states = line_q;

endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
    import coh_pkg::*;
(
    input  logic  snp_valid,
    input  bcmd_t snp_cmd,
    input  mesi_t cur,
    output logic  shared,
    output logic  supply,
    output logic  take_upd,
    output logic  we,
    output mesi_t nxt
);

    always_comb begin
        shared   = 1'b0;
        supply   = 1'b0;
        take_upd = 1'b0;
        nxt      = cur;
        if (snp_valid) begin
            unique case (snp_cmd)
                BC_RD: begin
                    shared = (cur != ST_I);
                    supply = (cur == ST_M);
                    if (cur == ST_M || cur == ST_E) nxt = ST_S;
                end
                BC_RDX: begin
                    supply = (cur == ST_M);
                    nxt    = ST_I;
                end
                BC_UPGR: nxt = ST_I;
                BC_UPD: begin
                    shared   = (cur != ST_I);
                    take_upd = (cur != ST_I);
                    supply   = (cur == ST_M);
                    if (cur == ST_M || cur == ST_E) nxt = ST_S;
                end
                default: nxt = cur;
            endcase
        end
        we = snp_valid && (nxt != cur);
    end

    always_comb begin
        if (supply) begin
            assert_supply_owner_R7: assert (cur == ST_M);
        end
    end

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_req,
    input  lop_t             loc_op,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic             loc_upd,
    input  mesi_t            cur_st,
    input  logic             snp_same,
    input  logic             bus_gnt,
    input  logic             bus_shared_in,
    output logic             loc_ready,
    output logic             loc_done,
    output logic             loc_hit,
    output mesi_t            loc_state,
    output logic             bus_req,
    output bcmd_t            bus_cmd,
    output logic [IDX_W-1:0] req_idx,
    output logic             lwe,
    output mesi_t            lst
);

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_DONE = 2'd2
    } fs_t;

    fs_t              fs_q, fs_d;
    lop_t             op_q;
    logic             upd_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit_q;
    mesi_t            res_q;
    bcmd_t            act;
    logic             complete;

    // Decision is recomputed from the live line state every cycle.
    always_comb begin
        act      = local_cmd(op_q, cur_st, upd_q);
        complete = (fs_q == FS_REQ) && ((act == BC_NONE) ? !snp_same : bus_gnt);
        lst      = local_next(op_q, cur_st, upd_q, (act != BC_NONE) && bus_shared_in);
    end

    always_comb begin
        fs_d = fs_q;
        unique case (fs_q)
            FS_IDLE: if (loc_req)  fs_d = FS_REQ;
            FS_REQ:  if (complete) fs_d = FS_DONE;
            FS_DONE: fs_d = FS_IDLE;
            default: fs_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= FS_IDLE;
        else        fs_q <= fs_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NOP;
            upd_q <= 1'b0;
            idx_q <= '0;
            hit_q <= 1'b0;
            res_q <= ST_I;
        end else begin
            if (fs_q == FS_IDLE && loc_req) begin
                op_q  <= loc_op;
                upd_q <= loc_upd;
                idx_q <= loc_idx;
            end
            if (complete) begin
                hit_q <= (act == BC_NONE);
                res_q <= lst;
            end
        end
    end

    always_comb begin
        loc_ready = (fs_q == FS_IDLE);
        loc_done  = (fs_q == FS_DONE);
        loc_hit   = hit_q;
        loc_state = res_q;
        bus_req   = (fs_q == FS_REQ) && (act != BC_NONE);
        bus_cmd   = bus_req ? act : BC_NONE;
        req_idx   = idx_q;
        lwe       = complete;
    end

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        loc_done |=> !loc_done);

    assert_idx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> $stable(req_idx));

    assert_silent_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q == FS_REQ && op_q == OP_WR && (cur_st == ST_E || cur_st == ST_M)) |-> !bus_req);

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_req,
    input  logic [1:0]       loc_op,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic             loc_upd_mode,
    output logic             loc_ready,
    output logic             loc_done,
    output logic             loc_hit,
    output logic [1:0]       loc_state,
    output logic             bus_req,
    output logic [2:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt,
    input  logic             bus_shared_in,
    input  logic             snp_valid,
    input  logic [2:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_shared,
    output logic             snp_supply,
    output logic             snp_take_upd
);

    mesi_t            st_req, st_snp, lst, sst, loc_st_e;
    mesi_t            states [NUM_LINES];
    bcmd_t            bcmd_e;
    logic             lwe, swe, snp_same;
    logic [IDX_W-1:0] req_idx;

    assign snp_same = snp_valid && (snp_idx == req_idx);

    coh_req_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .loc_req       (loc_req),
        .loc_op        (lop_t'(loc_op)),
        .loc_idx       (loc_idx),
        .loc_upd       (loc_upd_mode),
        .cur_st        (st_req),
        .snp_same      (snp_same),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .loc_ready     (loc_ready),
        .loc_done      (loc_done),
        .loc_hit       (loc_hit),
        .loc_state     (loc_st_e),
        .bus_req       (bus_req),
        .bus_cmd       (bcmd_e),
        .req_idx       (req_idx),
        .lwe           (lwe),
        .lst           (lst)
    );

    coh_snoop_resp u_snp (
        .snp_valid (snp_valid),
        .snp_cmd   (bcmd_t'(snp_cmd)),
        .cur       (st_snp),
        .shared    (snp_shared),
        .supply    (snp_supply),
        .take_upd  (snp_take_upd),
        .we        (swe),
        .nxt       (sst)
    );

    coh_state_table #(.NUM_LINES(NUM_LINES)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lwe    (lwe),
        .lidx   (req_idx),
        .lst    (lst),
        .swe    (swe),
        .sidx   (snp_idx),
        .sst    (sst),
        .ridx_a (req_idx),
        .rd_a   (st_req),
        .ridx_b (snp_idx),
        .rd_b   (st_snp),
        .states (states)
    );

    assign bus_cmd   = bcmd_e;
    assign bus_idx   = req_idx;
    assign loc_state = loc_st_e;

    assert_inval_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == BC_RDX || snp_cmd == BC_UPGR) && !(lwe && req_idx == snp_idx))
        |=> (states[$past(snp_idx)] == ST_I));

    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_RD)
        |=> (states[$past(bus_idx)] == ($past(bus_shared_in) ? ST_S : ST_E)));

endmodule

// File: tb/coh_ctrl_bench.sv
module coh_ctrl_bench;
    import coh_pkg::*;

    localparam int NL = 16;
    localparam int IW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loc_req = 1'b0;
    logic [1:0]    loc_op = 2'd0;
    logic [IW-1:0] loc_idx = '0;
    logic          loc_upd_mode = 1'b0;
    logic          loc_ready, loc_done, loc_hit;
    logic [1:0]    loc_state;
    logic          bus_req;
    logic [2:0]    bus_cmd;
    logic [IW-1:0] bus_idx;
    logic          bus_gnt = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [2:0]    snp_cmd = 3'd0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_shared, snp_supply, snp_take_upd;

    int checks = 0;
    int errors = 0;
    int model [NL];

    always #2 clk = ~clk;

    coh_ctrl #(.NUM_LINES(NL)) u_coh_ctrl (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected bus command from the requirements (R2..R6, R10).
    function automatic int exp_cmd(int op, int st, int upd);
        if (op == 0) return (st == 0) ? 1 : 0;
        if (op == 2) return (st == 3) ? 5 : 0;
        if (st >= 2) return 0;
        if (upd != 0) return 4;
        return (st == 1) ? 3 : 2;
    endfunction

    function automatic int exp_next(int op, int st, int upd, int shr);
        if (op == 2) return 0;
        if (op == 0) return (st != 0) ? st : (shr != 0 ? 1 : 2);
        if (st >= 2) return 3;
        if (upd != 0) return (shr != 0) ? 1 : 3;
        return 3;
    endfunction

    function automatic string op_tag(int op, int st, int upd);
        if (op == 0) return (st == 0) ? "R3" : "R2";
        if (op == 2) return "R10";
        if (st >= 2) return "R4";
        return (upd != 0) ? "R6" : "R5";
    endfunction

    // shr_sel: 0 or 1 forces bus_shared_in, 2 picks it at random
    task automatic do_local(input int op, input int idx, input int upd, input int shr_sel);
        int st, ec, shr, en;
        string tg;
        st = model[idx];
        ec = exp_cmd(op, st, upd);
        tg = op_tag(op, st, upd);
        shr = 0;
        @(negedge clk);
        check(loc_ready == 1'b1, "R12", "loc_ready before request", int'(loc_ready), 1);
        loc_req = 1'b1; loc_op = 2'(op); loc_idx = IW'(idx); loc_upd_mode = upd[0];
        @(negedge clk);
        loc_req = 1'b0;
        if (ec == 0) begin
            check(bus_req == 1'b0, tg, "bus_req when none expected", int'(bus_req), 0);
        end else begin
            check(bus_req == 1'b1 && int'(bus_cmd) == ec, tg, "bus_cmd", int'(bus_cmd), ec);
            for (int w = int'($urandom % 4); w > 0; w--) begin
                @(negedge clk);
                check(bus_req == 1'b1 && int'(bus_idx) == idx, "R12", "bus_idx held",
                      int'(bus_idx), idx);
            end
            shr = (shr_sel == 2) ? int'($urandom % 2) : shr_sel;
            bus_gnt = 1'b1; bus_shared_in = shr[0];
        end
        @(negedge clk);
        bus_gnt = 1'b0; bus_shared_in = 1'b0;
        en = exp_next(op, st, upd, shr);
        check(loc_done == 1'b1, tg, "loc_done", int'(loc_done), 1);
        check(loc_hit == (ec == 0), tg, "loc_hit", int'(loc_hit), int'(ec == 0));
        check(int'(loc_state) == en, tg, "loc_state", int'(loc_state), en);
        model[idx] = en;
        @(negedge clk);
        check(loc_done == 1'b0, "R12", "loc_done pulse width", int'(loc_done), 0);
    endtask

    task automatic do_snoop(input int cmd, input int idx);
        int st, e_sh, e_sp, e_tk, e_nx;
        string tg;
        st = model[idx];
        e_sh = ((cmd == 1 || cmd == 4) && st != 0) ? 1 : 0;
        e_sp = ((cmd == 1 || cmd == 2 || cmd == 4) && st == 3) ? 1 : 0;
        e_tk = (cmd == 4 && st != 0) ? 1 : 0;
        e_nx = st;
        if (cmd == 1 || cmd == 4) e_nx = (st >= 2) ? 1 : st;
        if (cmd == 2 || cmd == 3) e_nx = 0;
        tg = (cmd == 1) ? "R7" : (cmd == 4) ? "R9" : "R8";
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_idx = IW'(idx);
        #1;
        check(snp_shared == e_sh[0], tg, "snp_shared", int'(snp_shared), e_sh);
        check(snp_supply == e_sp[0], tg, "snp_supply", int'(snp_supply), e_sp);
        check(snp_take_upd == e_tk[0], tg, "snp_take_upd", int'(snp_take_upd), e_tk);
        @(negedge clk);
        snp_valid = 1'b0;
        model[idx] = e_nx;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        for (int i = 0; i < NL; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(loc_ready == 1'b1, "R1", "loc_ready after reset", int'(loc_ready), 1);
        check(bus_req == 1'b0, "R1", "bus_req after reset", int'(bus_req), 0);
        check(loc_done == 1'b0, "R1", "loc_done after reset", int'(loc_done), 0);

        // R1: every line reads as Invalid (first read must miss)
        for (int i = 0; i < NL; i++) do_local(0, i, 0, 2);

        // Directed per-requirement cases
        do_local(2, 0, 0, 0);       // clean evict, R10
        do_local(0, 0, 0, 0);       // fill E, R3
        do_local(1, 0, 0, 0);       // E -> M silent, R4
        do_snoop(1, 0);             // M supplies, -> S, R7
        do_local(1, 0, 1, 1);       // update write, peers answer: stays S, R6
        do_local(1, 0, 1, 0);       // update write, no peer: M, R6
        do_snoop(4, 0);             // take update, supply, -> S, R9
        do_local(1, 0, 0, 0);       // S upgrade, R5
        do_snoop(2, 0);             // RDX drops M to I with supply, R8
        do_local(1, 0, 0, 0);       // write miss RDX, R5
        do_snoop(5, 0);             // WB snoop: no effect, R8
        do_local(0, 0, 0, 0);       // read hit still M, R2
        do_local(2, 0, 0, 0);       // dirty evict WB, R10

        // R11: snoop RDX lands while UPGR waits for grant
        do_local(2, 3, 0, 0);
        do_local(0, 3, 0, 1);       // line 3 Shared
        @(negedge clk);
        loc_req = 1'b1; loc_op = 2'd1; loc_idx = IW'(3); loc_upd_mode = 1'b0;
        @(negedge clk);
        loc_req = 1'b0;
        check(bus_req && bus_cmd == 3'd3, "R11", "initial UPGR", int'(bus_cmd), 3);
        snp_valid = 1'b1; snp_cmd = 3'd2; snp_idx = IW'(3);
        @(negedge clk);
        snp_valid = 1'b0;
        check(bus_req && bus_cmd == 3'd2, "R11", "command follows to RDX", int'(bus_cmd), 2);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        check(loc_done && loc_state == 2'd3, "R11", "state after RDX", int'(loc_state), 3);
        model[3] = 3;
        @(negedge clk);

        // R11: snoop read turns a waiting dirty evict clean
        @(negedge clk);
        loc_req = 1'b1; loc_op = 2'd2; loc_idx = IW'(3); loc_upd_mode = 1'b0;
        @(negedge clk);
        loc_req = 1'b0;
        check(bus_req && bus_cmd == 3'd5, "R11", "initial WB", int'(bus_cmd), 5);
        snp_valid = 1'b1; snp_cmd = 3'd1; snp_idx = IW'(3);
        #1;
        check(snp_supply == 1'b1, "R7", "supply from waiting M line", int'(snp_supply), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        check(bus_req == 1'b0, "R11", "WB withdrawn", int'(bus_req), 0);
        @(negedge clk);
        check(loc_done && loc_hit && loc_state == 2'd0, "R11", "evict as hit",
              int'(loc_state), 0);
        model[3] = 0;
        @(negedge clk);

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int pick, idx;
            pick = int'($urandom % 10);
            idx  = int'($urandom % NL);
            if (pick < 6) begin
                do_local(int'($urandom % 3), idx, int'($urandom % 2), 2);
            end else begin
                int c;
                c = 1 + int'($urandom % 5);
                do_snoop(c, idx);
            end
        end

        // Final sweep: reading every line confirms the tracked states
        for (int i = 0; i < NL; i++) do_local(0, i, 0, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule